// File: doc/BRIEF.md
# Buffer-Aware Streaming Write Controller

This controller sits on the master side of a word-wide write path to a slave device that takes data into a ring of equal-size receive buffers. It pulls 32-bit words from an upstream valid/ready source and places each accepted word on a parallel data bus with a one-cycle write strobe. Each strobe moves four bytes to the slave.

Two counters track how much data has gone out. One counts the words in the current slave buffer. The other counts the words in the whole ring. When a buffer fills, the controller stops driving for a fixed number of cycles so the slave can move to its next buffer. When the whole ring fills, it goes back to idle. It starts again only after the slave raises its buffer-available flag. A buffer index output and a buffer-completed pulse show where the transfer stands.

By default a buffer holds 256 words (1 KiB), the ring has 8 buffers (2048 words, 8 KiB), and the switch gap is 2000 cycles. All three values are parameters.

Top module: `buf_stream_writer`

## Requirements
- R1: `src_ready` is high only in the drive state. While it is high, a word is accepted in every cycle that `src_valid` is high. In that cycle `bus_data` equals `src_data`. In every other cycle `bus_data` is zero.
- R2: `bus_wr` is high exactly in the drive-state cycles where `src_valid` is high. A cycle where `src_valid` is low moves no word and does not change either counter.
- R3: When the BUF_WORDS-th word of a buffer is accepted and the ring is not full, the controller pauses for exactly SWITCH_CYCLES cycles. During the pause `src_ready` and `bus_wr` stay low. The controller then resumes driving, with the per-buffer count back at zero.
- R4: When the (BUF_WORDS*NUM_BUFS)-th word of the ring is accepted, the controller goes straight to idle and clears both counters. This path takes priority over the switch pause, even though the same word also completes a buffer.
- R5: In idle, nothing is driven. When `slv_buf_avail` is sampled high at a clock edge, driving begins in the next cycle. While the flag is low, the controller stays in idle.
- R6: `buf_index` equals the number of buffers completed in the current ring, which is the ring word count divided by BUF_WORDS. It runs from 0 to NUM_BUFS-1.
- R7: `buf_done` is high for exactly one cycle: the cycle after the word that completes any buffer, including the last buffer of the ring.
- R8: A synchronous active-high `rst` puts the controller in idle, clears both counters and the switch timer, and holds `bus_wr`, `src_ready` and `buf_done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_data | input | 32 | Word offered by the upstream source |
| src_valid | input | 1 | Upstream word present |
| src_ready | output | 1 | Controller can take a word this cycle |
| bus_data | output | 32 | Data bus to the slave |
| bus_wr | output | 1 | Write strobe, one word per high cycle |
| slv_buf_avail | input | 1 | Slave reports a freed buffer |
| buf_index | output | 3 | Index of the slave buffer being filled |
| buf_done | output | 1 | One-cycle pulse after each buffer completes |

## Verification
The strobe, the data bus and `src_ready` are combinational in the current state and `src_valid`, so they are due in the same cycle as the stimulus. A state change caused by a sampled input, such as leaving idle on the flag or entering the pause, shows up one cycle after the edge that samples it. `buf_done` and `buf_index` also follow one cycle after the deciding word. The pause lasts exactly SWITCH_CYCLES cycles. The bench sets the inputs on the falling edge, lets them settle, and compares every output against a behavioural model. It then advances the model by what the coming rising edge will do, so each result is checked in the cycle it is due.

// File: rtl/wr_ctl_pkg.sv
package wr_ctl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRIVE = 2'd1,
    ST_GAP   = 2'd2
  } wr_state_t;

  // width needed to hold values 0..limit-1
  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit > 1) ? $clog2(limit) : 1;
  endfunction

  // which slave buffer a ring word count falls into
  function automatic int unsigned buf_of_word(input int unsigned ring_words,
                                               input int unsigned per_buf);
    return ring_words / per_buf;
  endfunction

endpackage

// File: rtl/wr_word_counter.sv
module wr_word_counter #(
  parameter int unsigned LIMIT = 256
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   inc,
  input  logic                                   clr,
  output logic [wr_ctl_pkg::cnt_width(LIMIT)-1:0] count,
  output logic                                   at_last
);
  localparam int unsigned CW = wr_ctl_pkg::cnt_width(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (inc)   count <= count + 1'b1;
  end

  assign at_last = (count == LAST);

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
    count <= LAST);
endmodule

// File: rtl/wr_gap_timer.sv
module wr_gap_timer #(
  parameter int unsigned CYCLES = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  localparam int unsigned TW = wr_ctl_pkg::cnt_width(CYCLES);
  localparam logic [TW-1:0] TLAST = TW'(CYCLES - 1);

  logic [TW-1:0] ticks;

  always_ff @(posedge clk) begin
    if (rst || !run || expired) ticks <= '0;
    else                        ticks <= ticks + 1'b1;
  end

  assign expired = run && (ticks == TLAST);

  assert_gap_bound_R3: assert property (@(posedge clk) disable iff (rst)
    ticks <= TLAST);
endmodule

// File: rtl/buf_stream_writer.sv
module buf_stream_writer #(
  parameter int unsigned WORD_W        = 32,
  parameter int unsigned BUF_WORDS     = 256,
  parameter int unsigned NUM_BUFS      = 8,
  parameter int unsigned SWITCH_CYCLES = 2000
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [WORD_W-1:0]           src_data,
  input  logic                        src_valid,
  output logic                        src_ready,
  output logic [WORD_W-1:0]           bus_data,
  output logic                        bus_wr,
  input  logic                        slv_buf_avail,
  output logic [$clog2(NUM_BUFS)-1:0] buf_index,
  output logic                        buf_done
);
  import wr_ctl_pkg::*;

  localparam int unsigned RING_WORDS = BUF_WORDS * NUM_BUFS;
  localparam int unsigned BCW        = cnt_width(BUF_WORDS);
  localparam int unsigned RCW        = cnt_width(RING_WORDS);
  localparam int unsigned IDX_W      = $clog2(NUM_BUFS);

  wr_state_t state, state_nx;
  logic [BCW-1:0] buf_cnt;
  logic [RCW-1:0] ring_cnt;
  logic buf_last, ring_last, gap_expired;

  // named events shared by the logic and the assertions
  logic word_xfer, buf_end_evt, ring_end_evt;

  assign src_ready    = (state == ST_DRIVE);
  assign word_xfer    = src_ready && src_valid;
  assign buf_end_evt  = word_xfer && buf_last;
  assign ring_end_evt = word_xfer && ring_last;
  assign bus_wr       = word_xfer;
  assign bus_data     = word_xfer ? src_data : '0;

  wr_word_counter #(.LIMIT(BUF_WORDS)) u_buf_cnt (
    .clk(clk), .rst(rst), .inc(word_xfer), .clr(buf_end_evt),
    .count(buf_cnt), .at_last(buf_last));

  wr_word_counter #(.LIMIT(RING_WORDS)) u_ring_cnt (
    .clk(clk), .rst(rst), .inc(word_xfer), .clr(ring_end_evt),
    .count(ring_cnt), .at_last(ring_last));

  wr_gap_timer #(.CYCLES(SWITCH_CYCLES)) u_gap (
    .clk(clk), .rst(rst), .run(state == ST_GAP), .expired(gap_expired));

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (slv_buf_avail) state_nx = ST_DRIVE;
      ST_DRIVE: begin
        if (ring_end_evt)     state_nx = ST_IDLE;   // ring end wins
        else if (buf_end_evt) state_nx = ST_GAP;
      end
      ST_GAP:   if (gap_expired) state_nx = ST_DRIVE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      buf_done <= 1'b0;
    end else begin
      state    <= state_nx;
      buf_done <= buf_end_evt;
    end
  end

  assign buf_index = IDX_W'(buf_of_word(32'(ring_cnt), BUF_WORDS));

  // ---- assertions ----
  assert_gap_entry_R3: assert property (@(posedge clk) disable iff (rst)
    (buf_end_evt && !ring_end_evt) |=> (state == ST_GAP) && !src_ready && buf_cnt == '0);

  assert_gap_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_GAP) |-> !bus_wr);

  assert_ring_idle_R4: assert property (@(posedge clk) disable iff (rst)
    ring_end_evt |=> (state == ST_IDLE) && ring_cnt == '0 && buf_cnt == '0);

  assert_start_on_flag_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(src_ready) |-> ($past(slv_buf_avail) || $past(state == ST_GAP)));

  assert_hold_empty_R2: assert property (@(posedge clk) disable iff (rst)
    (src_ready && !src_valid) |=> $stable(ring_cnt) && $stable(buf_cnt));

  assert_index_range_R6: assert property (@(posedge clk) disable iff (rst)
    32'(buf_index) < NUM_BUFS);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    buf_done |=> !buf_done);
endmodule

// File: tb/sim_buf_stream_writer.sv
module sim_buf_stream_writer;
  localparam int PERIOD = 10;
  localparam int BW = 4;
  localparam int NB = 4;
  localparam int SW = 3;
  localparam int TOT = BW * NB;

  logic clk = 0;
  logic rst;
  logic [31:0] src_data;
  logic src_valid, src_ready, bus_wr, slv_buf_avail, buf_done;
  logic [31:0] bus_data;
  logic [1:0] buf_index;

  int compared = 0, mismatched = 0;
  bit finished = 0;

  // reference model state: 0 idle, 1 drive, 2 gap
  int m_st, m_wb, m_wr, m_left, m_done;
  bit ring_just_ended;

  buf_stream_writer #(.WORD_W(32), .BUF_WORDS(BW), .NUM_BUFS(NB), .SWITCH_CYCLES(SW)) u0 (
    .clk(clk), .rst(rst), .src_data(src_data), .src_valid(src_valid),
    .src_ready(src_ready), .bus_data(bus_data), .bus_wr(bus_wr),
    .slv_buf_avail(slv_buf_avail), .buf_index(buf_index), .buf_done(buf_done));

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_st = 0; m_wb = 0; m_wr = 0; m_left = 0; m_done = 0; ring_just_ended = 0;
  endtask

  // one cycle: inputs set at negedge, outputs compared, model advanced
  task automatic step(input bit r, input bit v, input bit a);
    string tg;
    logic [31:0] d;
    @(negedge clk);
    d = $urandom;
    rst = r; src_valid = v; slv_buf_avail = a; src_data = d;
    #1;
    if (r) tg = "R8";
    else if (m_st == 2) tg = "R3";
    else if (m_st == 0 && ring_just_ended) tg = "R4";
    else if (m_st == 0) tg = "R5";
    else tg = "R1";
    chk(tg, "src_ready", src_ready, (m_st == 1));
    chk((m_st == 1) ? "R2" : tg, "bus_wr", bus_wr, (m_st == 1 && v));
    chk("R1", "bus_data", bus_data, (m_st == 1 && v) ? d : 0);
    chk("R6", "buf_index", buf_index, m_wr / BW);
    chk("R7", "buf_done", buf_done, m_done);
    // advance to what the rising edge will do
    if (r) model_reset();
    else begin
      m_done = 0;
      case (m_st)
        0: if (a) begin m_st = 1; ring_just_ended = 0; end
        1: if (v) begin
             m_wb++; m_wr++;
             if (m_wr == TOT) begin
               m_st = 0; m_wr = 0; m_wb = 0; m_done = 1; ring_just_ended = 1;
             end else if (m_wb == BW) begin
               m_wb = 0; m_st = 2; m_left = SW; m_done = 1;
             end
           end
        default: begin m_left--; if (m_left == 0) m_st = 1; end
      endcase
    end
  endtask

  initial begin
    rst = 1; src_valid = 0; slv_buf_avail = 0; src_data = 0;
    model_reset();
    for (int i = 0; i < 3; i++) step(1, 1, 1);        // R8 reset state
    for (int i = 0; i < 6; i++) step(0, 1, 0);        // R5 hold idle, flag low
    for (int i = 0; i < 40; i++) step(0, 1, 1);       // R3/R4 full ring, steady source
    for (int i = 0; i < 8; i++) step(0, 1, 0);        // R5 idle after ring
    for (int i = 0; i < 90; i++) step(0, (i % 3) != 0, (i % 7) < 3); // R2 gaps in source
    for (int i = 0; i < 60; i++) step(0, 1, i > 20);  // R4 ring end then re-arm
    step(1, 1, 1);                                    // R8 reset mid-stream
    for (int i = 0; i < 2; i++) step(1, 0, 0);
    for (int i = 0; i < 200; i++) step(0, $urandom_range(0, 3) != 0, $urandom_range(0, 1));
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule